// File: doc/BRIEF.md
# Positioned 16-bit Immediate Unit

This unit is one execute-stage slice of a 64-bit RISC core. It serves the instruction group that works on one 16-bit slot of a register. Each instruction carries a 16-bit immediate, and the unit drops that immediate into one of the four 16-bit slots of a 64-bit word. It then merges the result with the current register value using one of four operations: replace, add, OR, or clear the selected bits.

Decode hands the unit three things: the current register contents, the immediate, and two 2-bit selects, one for the slot and one for the operation. One cycle later the unit returns the value to write back, together with a valid strobe. Decode of the full instruction and register-file access stay outside the block.

Top module: `wyde_imm_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high in exactly the cycle that follows a cycle in which `in_valid` was high, and is low otherwise.
- R3: The immediate is placed by `pos_sel`. Code 0 puts it at bits 63..48, code 1 at 47..32, code 2 at 31..16 and code 3 at 15..0. The 48 bits outside the chosen slot of the placed value are zero.
- R4: `op_sel` = 0 (replace) returns the placed immediate alone. The old register value has no effect, and every bit outside the chosen slot is 0.
- R5: `op_sel` = 1 (add) returns the register value plus the placed immediate, modulo 2^64. A carry out of bit 63 is dropped without any flag.
- R6: `op_sel` = 2 (merge) returns the bitwise OR of the register value and the placed immediate.
- R7: `op_sel` = 3 (clear) returns the register value with every bit cleared that is set in the placed immediate.
- R8: In a cycle after one with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| reg_val | input | 64 | Current register contents |
| imm | input | 16 | Immediate field |
| pos_sel | input | 2 | Slot code (0 = top slot, 3 = bottom slot) |
| op_sel | input | 2 | Operation code (0 replace, 1 add, 2 OR, 3 clear) |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Value to write back |

## Verification
The bench sweeps all sixteen pairings of slot and operation with random register values and immediates. This separates a wrong slot code, a swapped operation and a wrong shift. Directed cases use an all-ones register with replace, which shows whether the old bits are cleared, and an all-ones register with an add of one in the bottom slot, which shows whether the carry out of bit 63 is dropped. A carry chain across slot boundaries shows whether the add treats the word as one 64-bit number. Idle gaps between requests show that the result holds and that the valid strobe drops.

// File: rtl/wimm_pkg.sv
package wimm_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned FIELD_W = 16;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_INC  = 2'd1,
    OP_OR   = 2'd2,
    OP_ANDN = 2'd3
  } wimm_op_e;
endpackage

// File: rtl/wimm_placer.sv
// Drops the immediate into one slot of a zero word; slot code 0 is the top slot.
module wimm_placer #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int SLOTS  = DATA_W / IMM_W,
  parameter int POS_W  = $clog2(SLOTS)
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] placed
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [POS_W-1:0] CODE = POS_W'(SLOTS - 1 - s);
    assign placed[s*IMM_W +: IMM_W] = (pos == CODE) ? imm : '0;
  end
endmodule

// File: rtl/wimm_combiner.sv
// Merges the placed immediate with the old register value.
module wimm_combiner
  import wimm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  wimm_op_e          op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] placed,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    unique case (op)
      OP_SET:  merged = placed;
      OP_INC:  merged = old_val + placed;
      OP_OR:   merged = old_val | placed;
      OP_ANDN: merged = old_val & ~placed;
      default: merged = placed;
    endcase
  end
endmodule

// File: rtl/wyde_imm_unit.sv
module wyde_imm_unit
  import wimm_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int IMM_W  = FIELD_W,
  localparam int SLOTS = DATA_W / IMM_W,
  localparam int POS_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [POS_W-1:0]  pos_sel,
  input  logic [1:0]        op_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] merged;

  wimm_placer #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SLOTS(SLOTS), .POS_W(POS_W)
  ) u_placer (
    .imm(imm), .pos(pos_sel), .placed(placed)
  );

  wimm_combiner #(.DATA_W(DATA_W)) u_comb (
    .op(wimm_op_e'(op_sel)), .old_val(reg_val), .placed(placed), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end
endmodule

// File: rtl/wimm_checker.sv
module wimm_checker #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] reg_val,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R8
  AST_SET_NARROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'd0) |=> ($countones(result) <= IMM_W)); // R4
  AST_OR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'd2) |=> ((result & $past(reg_val)) == $past(reg_val))); // R6
  AST_ANDN_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'd3) |=> ((result & ~$past(reg_val)) == '0)); // R7
endmodule

bind wyde_imm_unit wimm_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .reg_val(reg_val), .out_valid(out_valid), .result(result)
);

// File: tb/wyde_imm_unit_test.sv
module wyde_imm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] reg_val = '0;
  logic [15:0] imm = '0;
  logic [1:0]  pos_sel = '0;
  logic [1:0]  op_sel = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  always #4 clk = ~clk;

  wyde_imm_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .reg_val(reg_val), .imm(imm),
    .pos_sel(pos_sel), .op_sel(op_sel), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [63:0] r, logic [15:0] i,
                                        logic [1:0] p, logic [1:0] o);
    logic [63:0] pl;
    pl = {48'd0, i} << ((3 - int'(p)) * 16);
    case (o)
      2'd0: return pl;
      2'd1: return r + pl;
      2'd2: return r | pl;
      default: return r & ~pl;
    endcase
  endfunction

  function automatic string op_tag(logic [1:0] o);
    case (o)
      2'd0: return "R3+R4";
      2'd1: return "R3+R5";
      2'd2: return "R3+R6";
      default: return "R3+R7";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] r, logic [15:0] i, logic [1:0] p,
                       logic [1:0] o, string tag);
    @(negedge clk);
    in_valid = 1'b1; reg_val = r; imm = i; pos_sel = p; op_sel = o;
    exp_q.push_back(model(r, i, p, o));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      reg_val = {$urandom, $urandom};
    end
  endtask

  // Monitor: pops one expected item per valid result.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          last_exp = exp_q.pop_front();
          check(tag_q.pop_front(), result, last_exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    drive(64'hFFFF_FFFF_FFFF_FFFF, 16'hA5C3, 2'd0, 2'd0, "R4 set top clears rest");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 16'h0001, 2'd3, 2'd1, "R5 wrap to zero");
    drive(64'h0000_FFFF_FFFF_FFFF, 16'h0001, 2'd3, 2'd1, "R5 carry chain");
    drive(64'h1234_5678_9ABC_DEF0, 16'hFFFF, 2'd1, 2'd2, "R6 or slot MH");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 16'hF00F, 2'd2, 2'd3, "R7 andn slot ML");
    drive(64'hFFFF_0000_0000_0000, 16'h0001, 2'd0, 2'd1, "R5 top wrap");
    idle(3);
    check("R2 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R8 result holds when idle", result, last_exp);

    for (int o = 0; o < 4; o++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 6; k++) begin
          drive({$urandom, $urandom}, 16'($urandom), 2'(p), 2'(o), op_tag(2'(o)));
          if (k == 2) idle(1);
        end
      end
    end
    idle(4);
    check("R2 all results delivered", 64'(exp_q.size()), 64'd0);
    check("R8 hold at end", result, last_exp);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule